// File: doc/BRIEF.md
# Fractional Baud Tick Generator

This block turns the peripheral clock into the timing strobes that a serial receiver and transmitter need. A programmable divider with a 12-bit whole part and a 4-bit fraction sets the length of one oversampling period in clock cycles. The fraction is carried in a small phase accumulator, which lengthens some periods by one clock. The mean period therefore equals the programmed divider, and the baud rate is the clock frequency divided by (oversampling ratio × divider).

The oversampling ratio is 16 by default and 8 when the ratio select is high. The block gives a strobe for every oversampling instant, a strobe on the last sample of every bit, and the index of the sample within the bit. A bit decision stage reads the serial input around the middle of each bit. It takes either three samples, decided by majority with a noise indication, or a single centre sample. A synchronous restart input lets a framer realign the bit grid, for example on a start-bit edge.

Top module: `baud_tick_gen`

## Requirements
- R1: While reset is held, `sampIdx` is 0, `bitTick` is 0, `rxBit` is 1 and `rxNoise` is 0.
- R2: With `overBy8`=0, whole part N=`divInt` and fraction F=`divFrac`, sample tick number k (k ≥ 1, counted from the first cycle after reset or restart, that cycle being cycle 0) occurs in cycle k·N + floor(k·F/16) − 1. `sampleTick` is low in every other cycle.
- R3: With `overBy8`=1, the fraction used is F = 2·`divFrac`[2:0] in the formula of R2. `divFrac`[3] has no effect.
- R4: When `divInt` is 0, the divider acts as 1.0: `sampleTick` is high in every cycle and `divFrac` has no effect.
- R5: `sampIdx` is 0 in cycle 0 and advances by one after each sample tick. It returns to 0 after the tick taken at index 15 (ratio 16) or index 7 (ratio 8).
- R6: `bitTick` is high exactly in the cycles where `sampleTick` is high and `sampIdx` is the last index (15, or 7 with `overBy8`=1).
- R7: With `oneSample`=0, the serial input is taken on the sample ticks at indices 7, 8 and 9 (ratio 16) or 3, 4 and 5 (ratio 8). From the cycle after the last of these ticks, `rxBit` is the majority value of the three samples and `rxNoise` is 1 if and only if the three samples are not all equal.
- R8: With `oneSample`=1, only the sample at index 8 (ratio 16) or 4 (ratio 8) is used. At the same update point as in R7, `rxBit` takes that sample and `rxNoise` is 0.
- R9: A one-cycle `restart` pulse clears the period count, the fraction accumulator and `sampIdx`. The cycle after the pulse is cycle 0 of R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rstN | input | 1 | Active-low synchronous reset |
| restart | input | 1 | Realigns the divider and the bit grid |
| divInt | input | 12 | Whole part of the divider |
| divFrac | input | 4 | Fraction of the divider in sixteenths |
| overBy8 | input | 1 | 1 selects oversampling by 8, 0 by 16 |
| oneSample | input | 1 | 1 selects the single centre sample |
| rxIn | input | 1 | Serial input, already synchronised |
| sampleTick | output | 1 | Oversampling strobe |
| bitTick | output | 1 | Strobe on the last sample of each bit |
| sampIdx | output | 4 | Index of the sample within the bit |
| rxBit | output | 1 | Decided bit value |
| rxNoise | output | 1 | Disagreement among the voted samples |

## Verification
The bench builds the block with its default parameters: a 12-bit whole part, a 4-bit fraction and a top ratio of 16. It programs small whole parts (0 to 6) so that each run of a few hundred cycles spans many complete bit periods. Each run therefore reaches index wrap, accumulator carry and every vote point in both ratios. Fractions near 15, odd fractions with bit 3 set in ratio 8, and the clamped zero divider are directed cases. Random divider and mode settings fill in between them.

// File: rtl/baud_pkg.sv
package baud_pkg;
  // Strobes sent from the sequencer to the vote datapath
  typedef struct packed {
    logic capLo;   // take the early mid-bit sample
    logic capMid;  // take the centre sample
    logic commit;  // late sample is on rxIn now: decide the bit
  } voteStrobe_t;
endpackage

// File: rtl/baud_divider.sv
module baud_divider #(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic              overBy8,
  output logic              sampleTick
);
  localparam int CNT_W = INT_W + 1;

  logic [CNT_W-1:0]  cnt;
  logic [FRAC_W-1:0] acc;
  logic [INT_W-1:0]  intEff;
  logic [FRAC_W-1:0] fracEff;
  logic [FRAC_W:0]   accSum;
  logic              carry;
  logic [CNT_W-1:0]  limit;
  logic              clampOne;

  // A zero whole part is treated as 1.0, so the tick rate never exceeds clk.
  assign clampOne = (divInt == '0);

  // With ratio 8 the fraction is in eighths: scale by two, drop the top bit.
  always_comb begin
    if (clampOne) begin
      intEff  = INT_W'(1);
      fracEff = '0;
    end else begin
      intEff  = divInt;
      fracEff = overBy8 ? {divFrac[FRAC_W-2:0], 1'b0} : divFrac;
    end
  end

  assign accSum = {1'b0, acc} + {1'b0, fracEff};
  assign carry  = accSum[FRAC_W];
  assign limit  = {1'b0, intEff} - CNT_W'(1) + CNT_W'(carry);

  // >= keeps the strobe prompt when the divider shrinks mid-period
  assign sampleTick = (cnt >= limit);

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      cnt <= '0;
      acc <= '0;
    end else if (sampleTick) begin
      cnt <= '0;
      acc <= accSum[FRAC_W-1:0];
    end else begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  AST_CLAMP_RATE: assert property (@(posedge clk) disable iff (!rstN)
    (divInt == '0) |-> sampleTick); // R4

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && !restart && divInt >= INT_W'(2))
      |=> (!sampleTick || !$stable(divInt) || $past(restart))); // R2

  AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && !restart && divInt >= INT_W'(2) && !sampleTick == 1'b0)
      |=> (cnt == '0 || $past(restart))); // R9
endmodule

// File: rtl/baud_seq.sv
module baud_seq
  import baud_pkg::*;
#(
  parameter int OSR_HI = 16,
  parameter int IDX_W  = $clog2(OSR_HI)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  input  logic             sampleTick,
  input  logic             overBy8,
  input  logic             oneSample,
  output logic [IDX_W-1:0] sampIdx,
  output logic             bitTick,
  output voteStrobe_t      strobe
);
  localparam int OSR_LO = OSR_HI / 2;

  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] centreIdx;
  logic             tickLive;

  assign lastIdx   = overBy8 ? IDX_W'(OSR_LO - 1) : IDX_W'(OSR_HI - 1);
  assign centreIdx = overBy8 ? IDX_W'(OSR_LO / 2) : IDX_W'(OSR_HI / 2);
  assign tickLive  = sampleTick && !restart;

  assign bitTick = sampleTick && (sampIdx >= lastIdx);

  always_ff @(posedge clk) begin
    if (!rstN || restart) begin
      sampIdx <= '0;
    end else if (sampleTick) begin
      if (sampIdx >= lastIdx) sampIdx <= '0;
      else                    sampIdx <= sampIdx + IDX_W'(1);
    end
  end

  always_comb begin
    strobe.capLo  = tickLive && !oneSample && (sampIdx == centreIdx - IDX_W'(1));
    strobe.capMid = tickLive && (sampIdx == centreIdx);
    strobe.commit = tickLive && (sampIdx == centreIdx + IDX_W'(1));
  end

  AST_IDX_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    (sampleTick && !restart && sampIdx < lastIdx)
      |=> sampIdx == $past(sampIdx) + IDX_W'(1)); // R5

  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!sampleTick && !restart) |=> $stable(sampIdx)); // R5

  AST_BIT_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (bitTick && !restart) |=> sampIdx == '0); // R6

  AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> sampIdx == '0); // R9
endmodule

// File: rtl/baud_vote.sv
module baud_vote
  import baud_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        rxIn,
  input  logic        oneSample,
  input  voteStrobe_t strobe,
  output logic        rxBit,
  output logic        rxNoise
);
  logic sLo;
  logic sMid;
  logic majority;
  logic disagree;

  always_comb begin
    majority = (sLo & sMid) | (sLo & rxIn) | (sMid & rxIn);
    disagree = !((sLo == sMid) && (sMid == rxIn));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sLo     <= 1'b1;
      sMid    <= 1'b1;
      rxBit   <= 1'b1;
      rxNoise <= 1'b0;
    end else begin
      if (strobe.capLo)  sLo  <= rxIn;
      if (strobe.capMid) sMid <= rxIn;
      if (strobe.commit) begin
        if (oneSample) begin
          rxBit   <= sMid;
          rxNoise <= 1'b0;
        end else begin
          rxBit   <= majority;
          rxNoise <= disagree;
        end
      end
    end
  end

  AST_ONE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && oneSample) |=> !rxNoise); // R8

  AST_DECISION_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.commit |=> ($stable(rxBit) && $stable(rxNoise))); // R7

  AST_ONE_PICK: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.commit && oneSample) |=> rxBit == $past(sMid)); // R8
endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import baud_pkg::*;
#(
  parameter int INT_W  = 12,
  parameter int FRAC_W = 4,
  parameter int OSR_HI = 16,
  parameter int IDX_W  = $clog2(OSR_HI)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              restart,
  input  logic [INT_W-1:0]  divInt,
  input  logic [FRAC_W-1:0] divFrac,
  input  logic              overBy8,
  input  logic              oneSample,
  input  logic              rxIn,
  output logic              sampleTick,
  output logic              bitTick,
  output logic [IDX_W-1:0]  sampIdx,
  output logic              rxBit,
  output logic              rxNoise
);
  voteStrobe_t strobe;

  baud_divider #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_div (
    .clk(clk), .rstN(rstN), .restart(restart),
    .divInt(divInt), .divFrac(divFrac), .overBy8(overBy8),
    .sampleTick(sampleTick)
  );

  baud_seq #(.OSR_HI(OSR_HI), .IDX_W(IDX_W)) u_seq (
    .clk(clk), .rstN(rstN), .restart(restart),
    .sampleTick(sampleTick), .overBy8(overBy8), .oneSample(oneSample),
    .sampIdx(sampIdx), .bitTick(bitTick), .strobe(strobe)
  );

  baud_vote u_vote (
    .clk(clk), .rstN(rstN), .rxIn(rxIn), .oneSample(oneSample),
    .strobe(strobe), .rxBit(rxBit), .rxNoise(rxNoise)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    !rstN |=> (rxBit && !rxNoise && sampIdx == '0)); // R1
endmodule

// File: tb/sim_baud_tick_gen.sv
module sim_baud_tick_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN;
  logic        restart;
  logic [11:0] divInt;
  logic [3:0]  divFrac;
  logic        overBy8;
  logic        oneSample;
  logic        rxIn;
  logic        sampleTick;
  logic        bitTick;
  logic [3:0]  sampIdx;
  logic        rxBit;
  logic        rxNoise;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_tick_gen u0 (
    .clk(clk), .rstN(rstN), .restart(restart),
    .divInt(divInt), .divFrac(divFrac), .overBy8(overBy8),
    .oneSample(oneSample), .rxIn(rxIn),
    .sampleTick(sampleTick), .bitTick(bitTick), .sampIdx(sampIdx),
    .rxBit(rxBit), .rxNoise(rxNoise)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Cycle (from cycle 0) in which tick number k lands
  function automatic int tickCycle(input int k, input int n, input int f);
    return k * n + (k * f) / 16 - 1;
  endfunction

  function automatic bit maj3(input bit a, input bit b, input bit c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  task automatic runCase(input int n, input int f, input bit o8, input bit one,
                         input int cycles, input string tag);
    int ne, fe, osr, ctr, k;
    bit sLo, sMid, pend, pBit, pNoise, newRx, expTick, expBit;
    int expIdx;
    ne  = (n == 0) ? 1 : n;
    fe  = (n == 0) ? 0 : (o8 ? (f % 8) * 2 : f);
    osr = o8 ? 8 : 16;
    ctr = osr / 2;
    k = 0; pend = 0; sLo = 1; sMid = 1; pBit = 1; pNoise = 0;
    @(negedge clk);
    divInt = 12'(n); divFrac = 4'(f); overBy8 = o8; oneSample = one;
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    for (int c = 0; c < cycles; c++) begin
      if (pend) begin
        check(rxBit == pBit, one ? "R8 bit" : "R7 bit", rxBit, pBit);
        check(rxNoise == pNoise, one ? "R8 noise" : "R7 noise", rxNoise, pNoise);
        pend = 0;
      end
      expTick = (c == tickCycle(k + 1, ne, fe));
      expIdx  = k % osr;
      check(sampleTick == expTick,
            (n == 0) ? "R4 tick" : (o8 ? "R3 tick" : "R2 tick"), sampleTick, expTick);
      check(sampIdx == 4'(expIdx), (c == 0) ? "R9 idx" : "R5 idx", sampIdx, expIdx);
      check(bitTick == (expTick && expIdx == osr - 1), "R6 bitTick",
            bitTick, expTick && expIdx == osr - 1);
      newRx = ($urandom_range(3) == 0) ? ~rxIn : rxIn;
      rxIn = newRx;
      if (expTick) begin
        if (expIdx == ctr - 1) sLo = newRx;
        if (expIdx == ctr) sMid = newRx;
        if (expIdx == ctr + 1) begin
          pend = 1;
          if (one) begin
            pBit = sMid; pNoise = 0;
          end else begin
            expBit = maj3(sLo, sMid, newRx);
            pBit = expBit;
            pNoise = !((sLo == sMid) && (sMid == newRx));
          end
        end
        k++;
      end
      @(negedge clk);
    end
    if (tag.len() == 0) $display("case done");
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    finishRun();
  end

  initial begin
    void'($urandom(32'd4242));
    rstN = 1'b0; restart = 1'b0; divInt = 12'd9; divFrac = 4'd0;
    overBy8 = 1'b0; oneSample = 1'b0; rxIn = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset state
    check(sampIdx == 4'd0, "R1 idx", sampIdx, 0);
    check(bitTick == 1'b0, "R1 bitTick", bitTick, 0);
    check(rxBit == 1'b1, "R1 rxBit", rxBit, 1);
    check(rxNoise == 1'b0, "R1 rxNoise", rxNoise, 0);
    rstN = 1'b1;
    // directed corners
    runCase(4, 0, 0, 0, 600, "R2 plain");
    runCase(5, 7, 0, 0, 800, "R2 frac");
    runCase(3, 15, 0, 0, 800, "R2 max frac");
    runCase(6, 9, 1, 0, 600, "R3 bit3 ignored");
    runCase(6, 1, 1, 0, 600, "R3 low frac");
    runCase(2, 13, 1, 1, 500, "R8 one sample");
    runCase(3, 4, 0, 1, 600, "R8 ratio16");
    runCase(0, 9, 0, 0, 200, "R4 clamp");
    runCase(0, 5, 1, 0, 200, "R4 clamp ratio8");
    runCase(1, 5, 0, 0, 400, "R2 near one");
    // random settings
    for (int i = 0; i < 12; i++) begin
      runCase($urandom_range(6), $urandom_range(15), 1'($urandom_range(1)),
              1'($urandom_range(1)), 500, "random");
    end
    finishRun();
  end
endmodule